// File: doc/BRIEF.md
# Stereo Serial Audio Master Transmitter

This block drives a stereo serial audio link as the clock master and sends data only. A peripheral clock is divided by a 5-bit prescaler setting plus one to form the master clock. The bit clock runs at one twelfth of the master clock. This gives 32 bit slots per stereo frame and a sample rate equal to the master clock divided by 384. Samples arrive over a request/acknowledge DMA-style port and are queued in a 32-entry transmit FIFO. Each queue entry holds one channel sample. Entries alternate left and right.

Framing follows the standard two-channel serial audio format. Word select is low for the left channel. It changes one bit slot before the MSB of each channel. Data is sent MSB first and changes only when the bit clock falls.

A mode input selects 16-bit or 8-bit samples. In 8-bit mode the low byte of each entry is placed at the top of the 16-bit slot and the bits below it are zero. If the queue holds fewer than two entries when a frame begins, the frame carries zeros and a sticky underrun flag is raised.

Top module: `i2s_tx_master`

## Requirements
- R1: The bit clock period is 12·(n+1) peripheral clocks with 6·(n+1) high, and the word-select period is 384·(n+1) clocks, where n is `cfgPresc`.
- R2: With `cfgPrescEn` low, `mclk`, `bclk`, `ws` and `sdo` are low from the next cycle on. Enabling it again starts a fresh frame at slot 0 with a new sample pair.
- R3: Number the slots 0..31 from frame start, slot k being the k-th bit clock rising edge. `ws` is high in slots 15..30 and low in slots 31 and 0..14.
- R4: `sdo` holds the left sample MSB-first in slots 0..15 and the right sample in slots 16..31. It changes only while `bclk` is low.
- R5: With `cfgWide16` = 1 a slot carries entry bits [15:0]. With 0 it carries entry bits [7:0] followed by eight zeros.
- R6: The FIFO holds 32 entries. `dmaReq` is high exactly when `cfgDmaEn` and `cfgFifoEn` are both high and fewer than 32 entries are queued.
- R7: An acknowledge while the FIFO is full, or while `cfgFifoEn` is low, stores nothing. Dropping `cfgFifoEn` empties the FIFO.
- R8: A frame that starts with fewer than two queued entries sends zeros in both channels, consumes nothing and sets `underrun`. `underrun` then stays high until `underrunClr` is pulsed.
- R9: Each frame start with at least two entries consumes two. The older entry is the left channel.
- R10: For n ≥ 1 the master clock period is n+1 peripheral clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgPrescEn | input | 1 | Prescaler enable; all link clocks stop while low |
| cfgPresc | input | 5 | Prescaler setting n, divide by n+1 |
| cfgWide16 | input | 1 | 1 = 16-bit samples, 0 = 8-bit samples |
| cfgFifoEn | input | 1 | Transmit FIFO enable; low flushes it |
| cfgDmaEn | input | 1 | DMA request enable |
| underrunClr | input | 1 | Clears the underrun flag |
| dmaAck | input | 1 | Write strobe for one FIFO entry |
| dmaData | input | 16 | Sample written on acknowledge |
| dmaReq | output | 1 | FIFO has space and DMA service is on |
| mclk | output | 1 | Master clock |
| bclk | output | 1 | Serial bit clock |
| ws | output | 1 | Word select, low = left |
| sdo | output | 1 | Serial data |
| underrun | output | 1 | Sticky underrun flag |

## Verification
A slot or divider counter that is off by one shows up at the pins within one bit clock. The word-select pattern shifts, or the bit clock high time comes out other than six master clock ticks, and per-bit capture of `ws` over one frame exposes it. A wrong FIFO read pointer or count is visible by the next frame start: the pair sent differs from the pair queued, or the order swaps. A missed flush or an overfilled FIFO appears only when the queue drains, so the bench fills the queue completely and drains it through seventeen frames.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  typedef struct packed {
    logic halt;       // prescaler off: clear serializer
    logic frameLoad;  // start of a new stereo frame
    logic shiftBit;   // bit clock falling edge inside a frame
  } txStrobeT;
endpackage

// File: rtl/i2s_tx_ctrl.sv
module i2s_tx_ctrl
  import i2s_tx_pkg::*;
#(
  parameter int PRESC_W     = 5,
  parameter int SAMPLE_W    = 16,
  parameter int MCLK_PER_FS = 384
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgPrescEn,
  input  logic [PRESC_W-1:0] cfgPresc,
  output txStrobeT           strobe,
  output logic               mclk,
  output logic               bclk,
  output logic               ws
);
  localparam int FRAME_BITS = 2 * SAMPLE_W;
  localparam int BCLK_DIV   = MCLK_PER_FS / FRAME_BITS;
  localparam int DIV_W      = $clog2(BCLK_DIV);
  localparam int SLOT_W     = $clog2(FRAME_BITS);
  localparam logic [DIV_W-1:0]  DIV_LAST  = DIV_W'(BCLK_DIV - 1);
  localparam logic [DIV_W-1:0]  DIV_HALF  = DIV_W'(BCLK_DIV / 2);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(FRAME_BITS - 1);
  localparam logic [SLOT_W-1:0] WS_RISE   = SLOT_W'(SAMPLE_W - 1);
  localparam logic [SLOT_W-1:0] WS_FALL   = SLOT_W'(FRAME_BITS - 2);

  logic [PRESC_W-1:0] presCnt;
  logic [DIV_W-1:0]   bitDiv;
  logic [SLOT_W-1:0]  slot;
  logic               running;
  logic               tick;
  logic               bitEnd;

  assign tick   = cfgPrescEn && (presCnt >= cfgPresc);
  assign bitEnd = running && (bitDiv == DIV_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           presCnt <= '0;
    else if (!cfgPrescEn || tick) presCnt <= '0;
    else                 presCnt <= presCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      bitDiv  <= '0;
      slot    <= '0;
    end else if (!cfgPrescEn) begin
      running <= 1'b0;
      bitDiv  <= '0;
      slot    <= '0;
    end else if (tick) begin
      if (!running) begin
        running <= 1'b1;
        bitDiv  <= '0;
        slot    <= '0;
      end else if (bitEnd) begin
        bitDiv <= '0;
        slot   <= (slot == SLOT_LAST) ? '0 : slot + 1'b1;
      end else begin
        bitDiv <= bitDiv + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.halt      = !cfgPrescEn;
    strobe.frameLoad = tick && (!running || (bitEnd && slot == SLOT_LAST));
    strobe.shiftBit  = tick && bitEnd && (slot != SLOT_LAST);
  end

  assign mclk = cfgPrescEn && (presCnt <= (cfgPresc >> 1));
  assign bclk = running && (bitDiv >= DIV_HALF);
  assign ws   = running && (slot >= WS_RISE) && (slot <= WS_FALL);

  // R2: prescaler off silences the link clocks on the next cycle
  a_r2_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !cfgPrescEn |=> (!bclk && !ws));
  // R3: a frame always begins in the left half
  a_r3_left_first: assert property (@(posedge clk) disable iff (!rstN)
    strobe.frameLoad |=> !ws);
endmodule

// File: rtl/i2s_tx_dp.sv
module i2s_tx_dp
  import i2s_tx_pkg::*;
#(
  parameter int SAMPLE_W   = 16,
  parameter int FIFO_DEPTH = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWide16,
  input  logic                cfgFifoEn,
  input  logic                cfgDmaEn,
  input  logic                underrunClr,
  input  txStrobeT            strobe,
  input  logic                dmaAck,
  input  logic [SAMPLE_W-1:0] dmaData,
  output logic                dmaReq,
  output logic                sdo,
  output logic                underrun
);
  localparam int AW     = $clog2(FIFO_DEPTH);
  localparam int NARROW = SAMPLE_W / 2;
  localparam logic [AW:0] FULL = (AW+1)'(FIFO_DEPTH);
  localparam logic [AW:0] TWO  = (AW+1)'(2);

  logic [SAMPLE_W-1:0]   mem [FIFO_DEPTH];
  logic [AW-1:0]         wrPtr, rdPtr, rdNext;
  logic [AW:0]           count, countNext;
  logic                  push, pop, haveTwo;
  logic [2*SAMPLE_W-1:0] shiftReg;

  function automatic logic [SAMPLE_W-1:0] fmtSample(input logic wide, input logic [SAMPLE_W-1:0] d);
    return wide ? d : {d[NARROW-1:0], {(SAMPLE_W-NARROW){1'b0}}};
  endfunction

  assign rdNext  = rdPtr + 1'b1;
  assign haveTwo = count >= TWO;
  assign push    = dmaAck && cfgFifoEn && (count < FULL);
  assign pop     = strobe.frameLoad && haveTwo && cfgFifoEn;
  assign dmaReq  = cfgDmaEn && cfgFifoEn && (count < FULL);

  always_comb begin
    countNext = count;
    if (push) countNext = countNext + 1'b1;
    if (pop)  countNext = countNext - TWO;
  end

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= dmaData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (!cfgFifoEn) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + AW'(2);
      count <= countNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 shiftReg <= '0;
    else if (strobe.halt)      shiftReg <= '0;
    else if (strobe.frameLoad) shiftReg <= pop ? {fmtSample(cfgWide16, mem[rdPtr]),
                                                 fmtSample(cfgWide16, mem[rdNext])} : '0;
    else if (strobe.shiftBit)  shiftReg <= {shiftReg[2*SAMPLE_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            underrun <= 1'b0;
    else if (strobe.frameLoad && !pop)    underrun <= 1'b1;
    else if (underrunClr)                 underrun <= 1'b0;
  end

  assign sdo = shiftReg[2*SAMPLE_W-1];

  // R6: occupancy never exceeds the FIFO depth
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL);
  // R7: a full FIFO without a frame start stays full
  a_r7_full_hold: assert property (@(posedge clk) disable iff (!rstN)
    (count == FULL && cfgFifoEn && !strobe.frameLoad) |=> count == FULL);
  // R8: underrun is sticky until cleared
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (underrun && !underrunClr) |=> underrun);
  // R9: a served frame start takes exactly two entries
  a_r9_pop_two: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.frameLoad && haveTwo && !push && cfgFifoEn) |=> count == $past(count) - TWO);
endmodule

// File: rtl/i2s_tx_master.sv
module i2s_tx_master
  import i2s_tx_pkg::*;
#(
  parameter int PRESC_W     = 5,
  parameter int SAMPLE_W    = 16,
  parameter int FIFO_DEPTH  = 32,
  parameter int MCLK_PER_FS = 384
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgPrescEn,
  input  logic [PRESC_W-1:0]  cfgPresc,
  input  logic                cfgWide16,
  input  logic                cfgFifoEn,
  input  logic                cfgDmaEn,
  input  logic                underrunClr,
  input  logic                dmaAck,
  input  logic [SAMPLE_W-1:0] dmaData,
  output logic                dmaReq,
  output logic                mclk,
  output logic                bclk,
  output logic                ws,
  output logic                sdo,
  output logic                underrun
);
  txStrobeT strobe;

  i2s_tx_ctrl #(.PRESC_W(PRESC_W), .SAMPLE_W(SAMPLE_W), .MCLK_PER_FS(MCLK_PER_FS)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgPrescEn(cfgPrescEn), .cfgPresc(cfgPresc),
    .strobe(strobe), .mclk(mclk), .bclk(bclk), .ws(ws));

  i2s_tx_dp #(.SAMPLE_W(SAMPLE_W), .FIFO_DEPTH(FIFO_DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .cfgWide16(cfgWide16), .cfgFifoEn(cfgFifoEn),
    .cfgDmaEn(cfgDmaEn), .underrunClr(underrunClr), .strobe(strobe),
    .dmaAck(dmaAck), .dmaData(dmaData), .dmaReq(dmaReq), .sdo(sdo),
    .underrun(underrun));

  // R4: data holds steady while the bit clock stays high
  a_r4_sdo_stable: assert property (@(posedge clk) disable iff (!rstN)
    (bclk && $past(bclk)) |-> $stable(sdo));
endmodule

// File: tb/sim_i2s_tx_master.sv
`timescale 1ns/1ps
module sim_i2s_tx_master;
  logic clk = 1'b0, rstN = 1'b0;
  logic cfgPrescEn = 0, cfgWide16 = 1, cfgFifoEn = 0, cfgDmaEn = 0, underrunClr = 0, dmaAck = 0;
  logic [4:0]  cfgPresc = '0;
  logic [15:0] dmaData = '0;
  logic dmaReq, mclk, bclk, ws, sdo, underrun;
  int checks = 0, errors = 0, cyc = 0;

  localparam logic [31:0] WS_MASK = 32'h0001_FFFE;
  // {wide16, left entry, right entry, expected frame bits}
  localparam logic [64:0] VEC [5] = '{
    {1'b1, 16'hA5C3, 16'h3C5A, 32'hA5C3_3C5A},
    {1'b1, 16'h8000, 16'h0001, 32'h8000_0001},
    {1'b0, 16'h12F1, 16'hAB7E, 32'hF100_7E00},
    {1'b0, 16'h0080, 16'h00FF, 32'h8000_FF00},
    {1'b1, 16'hFFFF, 16'h0000, 32'hFFFF_0000}};

  i2s_tx_master u0 (.clk(clk), .rstN(rstN), .cfgPrescEn(cfgPrescEn), .cfgPresc(cfgPresc),
    .cfgWide16(cfgWide16), .cfgFifoEn(cfgFifoEn), .cfgDmaEn(cfgDmaEn),
    .underrunClr(underrunClr), .dmaAck(dmaAck), .dmaData(dmaData), .dmaReq(dmaReq),
    .mclk(mclk), .bclk(bclk), .ws(ws), .sdo(sdo), .underrun(underrun));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] d);
    @(negedge clk); dmaAck = 1'b1; dmaData = d;
    @(negedge clk); dmaAck = 1'b0;
  endtask

  task automatic capFrame(output logic [31:0] bits, output logic [31:0] wsBits);
    bits = '0; wsBits = '0;
    for (int k = 0; k < 32; k++) begin
      @(posedge bclk); #1;
      bits = {bits[30:0], sdo};
      wsBits = {wsBits[30:0], ws};
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] got, gotWs;
    int t0, t1, t2;
    repeat (3) @(negedge clk);
    check({mclk, bclk, ws, sdo} == 4'b0, "R2 reset outputs low", {mclk, bclk, ws, sdo}, 0);
    check(dmaReq == 1'b0 && underrun == 1'b0, "R6 reset no request", {dmaReq, underrun}, 0);
    rstN = 1'b1;
    @(negedge clk); cfgFifoEn = 1; cfgDmaEn = 1;
    #1 check(dmaReq == 1'b1, "R6 request with space", dmaReq, 1);

    // table of vectors, prescaler n=0
    foreach (VEC[i]) begin
      cfgWide16 = VEC[i][64];
      push(VEC[i][63:48]);
      push(VEC[i][47:32]);
      cfgPrescEn = 1'b1;
      capFrame(got, gotWs);
      @(negedge clk); cfgPrescEn = 1'b0;
      check(got == VEC[i][31:0], "R4 R5 R9 frame data", got, VEC[i][31:0]);
      check(gotWs == WS_MASK, "R3 word select slots", gotWs, WS_MASK);
      check(underrun == 1'b0, "R8 no spurious underrun", underrun, 0);
    end

    // fill to full, overflow attempt, drain through 17 frames
    @(negedge clk); cfgWide16 = 1;
    for (int i = 0; i < 32; i++) push(16'h0F00 + 16'(i));
    #1 check(dmaReq == 1'b0, "R6 request drops when full", dmaReq, 0);
    push(16'hDEAD); // R7 ignored while full
    cfgPrescEn = 1'b1;
    for (int f = 0; f < 17; f++) begin
      logic [31:0] exp;
      capFrame(got, gotWs);
      exp = (f < 16) ? {16'h0F00 + 16'(2*f), 16'h0F00 + 16'(2*f+1)} : 32'h0;
      check(got == exp, "R7 R9 drain order", got, exp);
    end
    @(negedge clk); cfgPrescEn = 1'b0;
    check(underrun == 1'b1, "R8 underrun set on empty", underrun, 1);
    repeat (4) @(negedge clk);
    check(underrun == 1'b1, "R8 underrun sticky", underrun, 1);
    underrunClr = 1'b1; @(negedge clk); underrunClr = 1'b0;
    check(underrun == 1'b0, "R8 underrun cleared", underrun, 0);

    // FIFO disabled: request off, acknowledge ignored
    cfgFifoEn = 1'b0;
    #1 check(dmaReq == 1'b0, "R6 no request when FIFO off", dmaReq, 0);
    push(16'hBEEF);
    push(16'hBEEF);
    cfgFifoEn = 1'b1; cfgPrescEn = 1'b1;
    capFrame(got, gotWs);
    @(negedge clk); cfgPrescEn = 1'b0;
    check(got == 32'h0, "R7 ack ignored while FIFO off", got, 0);
    check(underrun == 1'b1, "R8 underrun after ignored ack", underrun, 1);
    underrunClr = 1'b1; @(negedge clk); underrunClr = 1'b0;

    // clock ratios at n=3
    cfgPresc = 5'd3;
    push(16'h1111); push(16'h2222);
    cfgPrescEn = 1'b1;
    @(posedge mclk); #1 t0 = cyc;
    @(posedge mclk); #1 t1 = cyc;
    check(t1 - t0 == 4, "R10 mclk period", t1 - t0, 4);
    @(posedge bclk); #1 t0 = cyc;
    @(negedge bclk); #1 t1 = cyc;
    @(posedge bclk); #1 t2 = cyc;
    check(t1 - t0 == 24, "R1 bclk high time", t1 - t0, 24);
    check(t2 - t0 == 48, "R1 bclk period", t2 - t0, 48);
    @(posedge ws); #1 t0 = cyc;
    @(posedge ws); #1 t1 = cyc;
    check(t1 - t0 == 1536, "R1 frame period", t1 - t0, 1536);

    // disable mid-frame, then restart
    @(posedge bclk); @(negedge clk); cfgPrescEn = 1'b0;
    @(negedge clk);
    check({mclk, bclk, ws, sdo} == 4'b0, "R2 outputs low when off", {mclk, bclk, ws, sdo}, 0);
    repeat (20) @(negedge clk);
    check({mclk, bclk, ws, sdo} == 4'b0, "R2 outputs stay low", {mclk, bclk, ws, sdo}, 0);
    underrunClr = 1'b1; @(negedge clk); underrunClr = 1'b0;
    push(16'h1357); push(16'h2468);
    cfgPrescEn = 1'b1;
    capFrame(got, gotWs);
    @(negedge clk); cfgPrescEn = 1'b0;
    check(got == 32'h1357_2468, "R2 restart at slot 0", got, 32'h1357_2468);
    check(gotWs == WS_MASK, "R3 restart word select", gotWs, WS_MASK);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule